// File: doc/BRIEF.md
# Snooping MESI Coherence Controller

This block keeps coherence for a handful of cores that each own a small private line store on one shared snooping bus. Every block address has one slot in every core's store. Each slot is in one of four states: Invalid, Shared, Exclusive or Modified. A core presents load, store and evict requests. Requests that its local state can satisfy complete without the bus. The others become bus transactions:
- read
- read-for-ownership
- invalidate-upgrade
- update
- write-back

A round-robin arbiter admits one bus transaction per cycle. Every controller snoops that transaction in the same cycle. A peer with a valid copy raises the shared line. A peer holding the block Modified drives its data onto the bus in place of memory. A small backing memory sits behind the bus.

Each store request carries a page-policy bit. When it is 0, a store to a non-owned line removes every peer copy. When it is 1, the store broadcasts the new value instead: peers keep their copies, and memory is written at the same time. Coherence is tracked per block, so traffic on one block never holds up work on another.

Requests use valid/ready. A core holds `req_valid` and keeps the payload stable until `req_ready` is high in the same cycle. `req_ready` can fall because of a peer's bus traffic, and it can also fall because the arbiter granted another core. Load responses have no back-pressure: `rsp_valid` pulses for one cycle and the core must take the data then. Operation codes are 0 for load, 1 for store and 2 for evict. Code 3 is accepted and has no effect. Line state codes are 0 Invalid, 1 Shared, 2 Exclusive and 3 Modified. Bus command codes are 0 read, 1 read-for-ownership, 2 upgrade, 3 update and 4 write-back.

Top module: `mesi_snoop_sys`

## Requirements
- R1: After reset every slot of every core is Invalid (code 0), memory holds zero, and no `rsp_valid` is high.
- R2: A load to an Invalid slot issues a read (cmd 0). The slot fills as Exclusive (2) when no peer raises `bus_shared`, and as Shared (1) otherwise.
- R3: A store to an Exclusive or Modified slot completes with no bus transaction and leaves the slot Modified (3) with the new data.
- R4: A store with policy 0 to a Shared slot issues an upgrade (cmd 2), or a read-for-ownership (cmd 1) from Invalid. Every peer copy becomes Invalid, the requester becomes Modified, and while a slot is Exclusive or Modified no peer holds a valid copy of it.
- R5: A store with policy 1 to a Shared or Invalid slot issues an update (cmd 3). It writes memory, and every peer holding the block keeps it as Shared with the new value. The requester becomes Shared if `bus_shared` is high, and Exclusive otherwise.
- R6: A Modified peer that snoops a read raises `bus_supply` and supplies its data to the reader. Memory takes the same data, and the peer drops to Shared.
- R7: A Modified peer that snoops a read-for-ownership supplies its data and drops to Invalid. The requester ends Modified with the stored value.
- R8: Evicting a Modified slot issues a write-back (cmd 4) that updates memory and leaves the slot Invalid. Evicting a Shared or Exclusive slot makes it Invalid with no bus transaction.
- R9: At most one bus transaction is granted per cycle. Among waiting requesters, the grant goes to the first at or after the core following the last granted one.
- R10: A request that needs no bus is held off in any cycle when a peer's bus transaction targets the same block. A request to a different block completes in that same cycle.
- R11: An accepted load raises `rsp_valid` exactly one cycle later with the line's value: the local copy on a hit, the bus data on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NCORES | Per-core request valid |
| req_op | input | 2*NCORES | Per-core operation code |
| req_addr | input | AW*NCORES | Per-core block address |
| req_wdata | input | DW*NCORES | Per-core store data |
| req_upd | input | NCORES | Per-core page policy: 1 update, 0 invalidate |
| req_ready | output | NCORES | Per-core request accepted this cycle |
| rsp_valid | output | NCORES | Per-core load response valid |
| rsp_rdata | output | DW*NCORES | Per-core load response data |
| bus_valid | output | 1 | A bus transaction occurs this cycle |
| bus_cmd | output | 3 | Command of the current transaction |
| bus_addr | output | AW | Block address of the current transaction |
| bus_src | output | IW | Core that owns the current transaction |
| bus_shared | output | 1 | Some peer holds a valid copy of the block |
| bus_supply | output | 1 | A Modified peer is driving the data |
| line_state | output | 2*NLINES*NCORES | State of every slot, core-major |

## Verification
`req_ready` and the bus outputs are combinational in the cycle a request is presented. Slot states, memory and `rsp_valid`/`rsp_rdata` change at the next rising edge. The bench therefore drives inputs at the falling edge and compares the combinational outputs 1 ns later against a behavioural model of the same cycle. At the following falling edge it compares the registered outputs with the model's updated state. Directed sequences check specific slot codes and captured response data one idle cycle after the last acceptance. They also check the cycle numbers at which competing requests were accepted, and these are followed by a long random run.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} lstate_t;
  typedef enum logic [2:0] {BC_RD = 3'd0, BC_RFO = 3'd1, BC_UPG = 3'd2,
                            BC_UPD = 3'd3, BC_WB = 3'd4} bcmd_t;
  typedef enum logic [1:0] {OP_LD = 2'd0, OP_ST = 2'd1, OP_EV = 2'd2} cop_t;
endpackage

// File: rtl/mesi_rr_arb.sv
module mesi_rr_arb #(
  parameter int N  = 3,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic          gnt_valid,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] rr;
  int unsigned   cand;

  always_comb begin
    gnt       = '0;
    gnt_idx   = '0;
    gnt_valid = 1'b0;
    cand      = 0;
    for (int k = 0; k < N; k++) begin
      cand = (int'(rr) + k) % N;
      if (!gnt_valid && req[cand]) begin
        gnt_valid = 1'b1;
        gnt[cand] = 1'b1;
        gnt_idx   = IW'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rr <= '0;
    else if (gnt_valid) rr <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + 1'b1;
  end
endmodule

// File: rtl/mesi_line_ctl.sv
module mesi_line_ctl
  import mesi_pkg::*;
#(
  parameter int NLINES = 4,
  parameter int DW     = 8,
  parameter int AW     = $clog2(NLINES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          req_op,
  input  logic [AW-1:0]       req_addr,
  input  logic [DW-1:0]       req_wdata,
  input  logic                req_upd,
  output logic                req_ready,
  output logic                rsp_valid,
  output logic [DW-1:0]       rsp_rdata,
  output logic                bus_req,
  output logic [2:0]          bus_req_cmd,
  output logic [DW-1:0]       bus_req_data,
  input  logic                bus_gnt,
  input  logic                snp_valid,
  input  logic [2:0]          snp_cmd,
  input  logic [AW-1:0]       snp_addr,
  input  logic [DW-1:0]       snp_data,
  input  logic                snp_shared,
  input  logic [DW-1:0]       fill_data,
  output logic                snp_hit,
  output logic                snp_supply,
  output logic [DW-1:0]       snp_sdata,
  output logic [2*NLINES-1:0] state_o
);
  lstate_t       st  [NLINES];
  logic [DW-1:0] dat [NLINES];
  lstate_t       cur;
  logic          need, peer_busy, local_go, fire_ld;

  assign cur = st[req_addr];

  always_comb begin
    need        = 1'b0;
    bus_req_cmd = BC_RD;
    case (req_op)
      OP_LD: need = (cur == ST_I);
      OP_ST: begin
        need        = (cur == ST_I) || (cur == ST_S);
        bus_req_cmd = req_upd ? BC_UPD : ((cur == ST_S) ? BC_UPG : BC_RFO);
      end
      OP_EV: begin
        need        = (cur == ST_M);
        bus_req_cmd = BC_WB;
      end
      default: need = 1'b0;
    endcase
  end

  assign bus_req      = req_valid && need;
  assign bus_req_data = (req_op == OP_EV) ? dat[req_addr] : req_wdata;
  assign peer_busy    = snp_valid && !bus_gnt && (snp_addr == req_addr);
  assign local_go     = req_valid && !need && !peer_busy;
  assign req_ready    = local_go || bus_gnt;
  assign fire_ld      = req_valid && req_ready && (req_op == OP_LD);

  assign snp_hit    = snp_valid && !bus_gnt && (st[snp_addr] != ST_I);
  assign snp_supply = snp_hit && (st[snp_addr] == ST_M) &&
                      (snp_cmd == BC_RD || snp_cmd == BC_RFO);
  assign snp_sdata  = dat[snp_addr];

  always_comb
    for (int i = 0; i < NLINES; i++) state_o[2*i +: 2] = st[i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      for (int i = 0; i < NLINES; i++) begin
        st[i]  <= ST_I;
        dat[i] <= '0;
      end
    end else begin
      rsp_valid <= fire_ld;
      if (fire_ld) rsp_rdata <= bus_gnt ? fill_data : dat[req_addr];
      for (int i = 0; i < NLINES; i++) begin
        if (snp_valid && snp_addr == AW'(i)) begin
          if (bus_gnt) begin
            case (snp_cmd)
              BC_RD:  begin st[i] <= snp_shared ? ST_S : ST_E; dat[i] <= fill_data; end
              BC_RFO, BC_UPG: begin st[i] <= ST_M; dat[i] <= snp_data; end
              BC_UPD: begin st[i] <= snp_shared ? ST_S : ST_E; dat[i] <= snp_data; end
              BC_WB:  st[i] <= ST_I;
              default: ;
            endcase
          end else if (st[i] != ST_I) begin
            case (snp_cmd)
              BC_RD:          st[i] <= ST_S;
              BC_RFO, BC_UPG: st[i] <= ST_I;
              BC_UPD: begin st[i] <= ST_S; dat[i] <= snp_data; end
              default: ;
            endcase
          end
        end else if (local_go && req_addr == AW'(i)) begin
          if (req_op == OP_ST) begin
            st[i]  <= ST_M;
            dat[i] <= req_wdata;
          end else if (req_op == OP_EV) begin
            st[i] <= ST_I;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mesi_snoop_sys.sv
module mesi_snoop_sys
  import mesi_pkg::*;
#(
  parameter int NCORES  = 3,
  parameter int NLINES  = 4,
  parameter int DW      = 8,
  localparam int AW     = $clog2(NLINES),
  localparam int IW     = (NCORES > 1) ? $clog2(NCORES) : 1,
  localparam int SW     = 2 * NLINES
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCORES-1:0]        req_valid,
  input  logic [2*NCORES-1:0]      req_op,
  input  logic [AW*NCORES-1:0]     req_addr,
  input  logic [DW*NCORES-1:0]     req_wdata,
  input  logic [NCORES-1:0]        req_upd,
  output logic [NCORES-1:0]        req_ready,
  output logic [NCORES-1:0]        rsp_valid,
  output logic [DW*NCORES-1:0]     rsp_rdata,
  output logic                     bus_valid,
  output logic [2:0]               bus_cmd,
  output logic [AW-1:0]            bus_addr,
  output logic [IW-1:0]            bus_src,
  output logic                     bus_shared,
  output logic                     bus_supply,
  output logic [SW*NCORES-1:0]     line_state
);
  logic [NCORES-1:0]  breq, gnt, hit, sup;
  logic [2:0]         rcmd  [NCORES];
  logic [DW-1:0]      rdata [NCORES];
  logic [DW-1:0]      sdat  [NCORES];
  logic [DW-1:0]      bus_data, sup_data, fill_data;
  logic [DW-1:0]      mem [NLINES];

  mesi_rr_arb #(.N(NCORES), .IW(IW)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(breq), .gnt(gnt),
    .gnt_valid(bus_valid), .gnt_idx(bus_src)
  );

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    mesi_line_ctl #(.NLINES(NLINES), .DW(DW), .AW(AW)) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid[c]), .req_op(req_op[2*c +: 2]),
      .req_addr(req_addr[AW*c +: AW]), .req_wdata(req_wdata[DW*c +: DW]),
      .req_upd(req_upd[c]), .req_ready(req_ready[c]),
      .rsp_valid(rsp_valid[c]), .rsp_rdata(rsp_rdata[DW*c +: DW]),
      .bus_req(breq[c]), .bus_req_cmd(rcmd[c]), .bus_req_data(rdata[c]),
      .bus_gnt(gnt[c]), .snp_valid(bus_valid), .snp_cmd(bus_cmd),
      .snp_addr(bus_addr), .snp_data(bus_data), .snp_shared(bus_shared),
      .fill_data(fill_data), .snp_hit(hit[c]), .snp_supply(sup[c]),
      .snp_sdata(sdat[c]), .state_o(line_state[SW*c +: SW])
    );
  end

  always_comb begin
    bus_cmd  = '0;
    bus_addr = '0;
    bus_data = '0;
    sup_data = '0;
    for (int c = 0; c < NCORES; c++) begin
      if (gnt[c]) begin
        bus_cmd  = rcmd[c];
        bus_addr = req_addr[AW*c +: AW];
        bus_data = rdata[c];
      end
      if (sup[c]) sup_data = sup_data | sdat[c];
    end
  end

  assign bus_shared = |hit;
  assign bus_supply = |sup;
  assign fill_data  = bus_supply ? sup_data : mem[bus_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) mem[i] <= '0;
    end else if (bus_valid) begin
      if (bus_cmd == BC_RD && bus_supply) mem[bus_addr] <= sup_data;
      else if (bus_cmd == BC_UPD || bus_cmd == BC_WB) mem[bus_addr] <= bus_data;
    end
  end
endmodule

// File: rtl/mesi_sys_chk.sv
module mesi_sys_chk #(
  parameter int NCORES = 3,
  parameter int NLINES = 4,
  parameter int AW     = 2,
  parameter int IW     = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NCORES-1:0]          gnt,
  input logic [NCORES-1:0]          req_valid,
  input logic [NCORES-1:0]          req_ready,
  input logic [2*NCORES-1:0]        req_op,
  input logic [NCORES-1:0]          rsp_valid,
  input logic                       bus_valid,
  input logic [2:0]                 bus_cmd,
  input logic [AW-1:0]              bus_addr,
  input logic [IW-1:0]              bus_src,
  input logic                       bus_supply,
  input logic [2*NLINES*NCORES-1:0] line_state
);
  logic [NLINES-1:0] bad_own;
  logic              wb_pend;
  logic [IW-1:0]     wb_src;
  logic [AW-1:0]     wb_addr;
  logic [1:0]        wb_state;
  int                nv, nx;

  always_comb begin
    nv = 0;
    nx = 0;
    for (int a = 0; a < NLINES; a++) begin
      nv = 0;
      nx = 0;
      for (int c = 0; c < NCORES; c++) begin
        if (line_state[(c*NLINES + a)*2 +: 2] != 2'd0) nv++;
        if (line_state[(c*NLINES + a)*2 +: 2] >= 2'd2) nx++;
      end
      bad_own[a] = (nx > 0) && (nv > 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_pend <= 1'b0;
      wb_src  <= '0;
      wb_addr <= '0;
    end else begin
      wb_pend <= bus_valid && (bus_cmd == 3'd4);
      wb_src  <= bus_src;
      wb_addr <= bus_addr;
    end
  end
  assign wb_state = line_state[(int'(wb_src)*NLINES + int'(wb_addr))*2 +: 2];

  assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  assert_grant_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> req_ready[bus_src]);
  assert_supply_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_supply |-> (bus_valid && (bus_cmd == 3'd0 || bus_cmd == 3'd1)));
  assert_wb_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_pend |-> (wb_state == 2'd0));

  for (genvar c = 0; c < NCORES; c++) begin : g_rsp
    assert_load_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[c] && req_ready[c] && req_op[2*c +: 2] == 2'd0) |=> rsp_valid[c]);
  end
  for (genvar a = 0; a < NLINES; a++) begin : g_own
    assert_sole_owner_R4: assert property (@(posedge clk) disable iff (!rst_n) !bad_own[a]);
  end
endmodule

bind mesi_snoop_sys mesi_sys_chk #(.NCORES(NCORES), .NLINES(NLINES), .AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .gnt(gnt), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .rsp_valid(rsp_valid), .bus_valid(bus_valid), .bus_cmd(bus_cmd),
  .bus_addr(bus_addr), .bus_src(bus_src), .bus_supply(bus_supply), .line_state(line_state)
);

// File: tb/sim_mesi_snoop_sys.sv
module sim_mesi_snoop_sys;
  localparam int CLK_NS = 10;
  localparam int NC = 3, NL = 4, DW = 8, AW = 2, IW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NC-1:0] t_valid = '0, t_upd = '0, req_ready, rsp_valid;
  logic [2*NC-1:0] t_op = '0;
  logic [AW*NC-1:0] t_addr = '0;
  logic [DW*NC-1:0] t_wdata = '0, rsp_rdata;
  logic bus_valid, bus_shared, bus_supply;
  logic [2:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [IW-1:0] bus_src;
  logic [2*NL*NC-1:0] line_state;

  always #(CLK_NS/2) clk = ~clk;

  mesi_snoop_sys #(.NCORES(NC), .NLINES(NL), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(t_valid), .req_op(t_op), .req_addr(t_addr),
    .req_wdata(t_wdata), .req_upd(t_upd), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_src(bus_src), .bus_shared(bus_shared), .bus_supply(bus_supply),
    .line_state(line_state)
  );

  int checks = 0, fails = 0, cyc = 0, bus_cnt = 0, last_cmd = -1;
  int m_st [NC][NL], m_dat [NC][NL], m_mem [NL], m_rr = 0;
  int exp_rv [NC], exp_rd [NC], got_rd [NC], acc_cyc [NC];
  int pv [NC], pop [NC], pa [NC], pd [NC], pu [NC];
  int q_src [$];
  bit timed_out = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic int st_of(int c, int a);
    return int'(line_state[(c*NL + a)*2 +: 2]);
  endfunction

  function automatic int need_cmd(int c);
    int s = m_st[c][pa[c]];
    case (pop[c])
      0: return (s == 0) ? 0 : -1;
      1: return (s == 0) ? (pu[c] ? 3 : 1) : (s == 1) ? (pu[c] ? 3 : 2) : -1;
      2: return (s == 3) ? 4 : -1;
      default: return -1;
    endcase
  endfunction

  task automatic step();
    int g = -1, cmd = 0, a = 0, shared = 0, supply = 0, sdata = 0, fill = 0;
    int acc [NC], n_st [NC][NL], n_dat [NC][NL];
    cyc++;
    if (cyc > 150000) begin timed_out = 1; return; end
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      chk(rsp_valid[c] == exp_rv[c][0], "R11", "rsp_valid", int'(rsp_valid[c]), exp_rv[c]);
      if (exp_rv[c] != 0)
        chk(int'(rsp_rdata[DW*c +: DW]) == exp_rd[c], "R11", "rsp_rdata",
            int'(rsp_rdata[DW*c +: DW]), exp_rd[c]);
      if (rsp_valid[c]) got_rd[c] = int'(rsp_rdata[DW*c +: DW]);
      for (int l = 0; l < NL; l++)
        chk(st_of(c, l) == m_st[c][l], "R2", "line state", st_of(c, l), m_st[c][l]);
    end
    for (int c = 0; c < NC; c++) begin
      t_valid[c] = pv[c][0];
      t_op[2*c +: 2] = 2'(pop[c]);
      t_addr[AW*c +: AW] = AW'(pa[c]);
      t_wdata[DW*c +: DW] = DW'(pd[c]);
      t_upd[c] = pu[c][0];
    end
    #1;
    for (int k = 0; k < NC; k++) begin
      int idx = (m_rr + k) % NC;
      if (g < 0 && pv[idx] != 0 && need_cmd(idx) >= 0) g = idx;
    end
    if (g >= 0) begin
      cmd = need_cmd(g);
      a = pa[g];
      for (int c = 0; c < NC; c++)
        if (c != g && m_st[c][a] != 0) begin
          shared = 1;
          if (m_st[c][a] == 3 && cmd <= 1) begin supply = 1; sdata = m_dat[c][a]; end
        end
      fill = supply ? sdata : m_mem[a];
    end
    chk(bus_valid == (g >= 0), "R9", "bus_valid", int'(bus_valid), int'(g >= 0));
    if (g >= 0) begin
      chk(int'(bus_src) == g, "R9", "bus_src", int'(bus_src), g);
      chk(int'(bus_cmd) == cmd, "R4", "bus_cmd", int'(bus_cmd), cmd);
      chk(int'(bus_addr) == a, "R9", "bus_addr", int'(bus_addr), a);
      chk(int'(bus_shared) == shared, "R2", "bus_shared", int'(bus_shared), shared);
      chk(int'(bus_supply) == supply, "R6", "bus_supply", int'(bus_supply), supply);
      bus_cnt++;
      last_cmd = cmd;
      q_src.push_back(g);
    end
    n_st = m_st;
    n_dat = m_dat;
    for (int c = 0; c < NC; c++) begin
      acc[c] = (c == g) ||
               (pv[c] != 0 && need_cmd(c) < 0 && !(g >= 0 && pa[c] == a));
      chk(req_ready[c] == acc[c][0], "R10", "req_ready", int'(req_ready[c]), acc[c]);
      exp_rv[c] = (acc[c] != 0 && pop[c] == 0);
      if (exp_rv[c] != 0) exp_rd[c] = (c == g) ? fill : m_dat[c][pa[c]];
      if (acc[c] != 0 && c != g) begin
        if (pop[c] == 1) begin n_st[c][pa[c]] = 3; n_dat[c][pa[c]] = pd[c]; end
        else if (pop[c] == 2) n_st[c][pa[c]] = 0;
      end
    end
    if (g >= 0) begin
      for (int c = 0; c < NC; c++) begin
        if (c == g) begin
          case (cmd)
            0: begin n_st[c][a] = shared ? 1 : 2; n_dat[c][a] = fill; end
            1, 2: begin n_st[c][a] = 3; n_dat[c][a] = pd[c]; end
            3: begin n_st[c][a] = shared ? 1 : 2; n_dat[c][a] = pd[c]; end
            default: n_st[c][a] = 0;
          endcase
        end else if (m_st[c][a] != 0) begin
          if (cmd == 0) n_st[c][a] = 1;
          else if (cmd == 1 || cmd == 2) n_st[c][a] = 0;
          else if (cmd == 3) begin n_st[c][a] = 1; n_dat[c][a] = pd[g]; end
        end
      end
      if (cmd == 0 && supply != 0) m_mem[a] = sdata;
      else if (cmd == 3) m_mem[a] = pd[g];
      else if (cmd == 4) m_mem[a] = m_dat[g][a];
      m_rr = (g + 1) % NC;
    end
    m_st = n_st;
    m_dat = n_dat;
    for (int c = 0; c < NC; c++)
      if (acc[c] != 0) begin pv[c] = 0; acc_cyc[c] = cyc; end
  endtask

  task automatic put(int c, int op, int a, int d, int u);
    pv[c] = 1; pop[c] = op; pa[c] = a; pd[c] = d; pu[c] = u;
  endtask

  task automatic run();
    int guard = 0;
    while ((pv[0] | pv[1] | pv[2]) != 0 && guard < 50 && !timed_out) begin
      step();
      guard++;
    end
    step();
  endtask

  initial begin
    int b;
    for (int c = 0; c < NC; c++) begin
      pv[c] = 0; exp_rv[c] = 0; exp_rd[c] = 0; got_rd[c] = -1; acc_cyc[c] = 0;
      for (int l = 0; l < NL; l++) begin m_st[c][l] = 0; m_dat[c][l] = 0; end
    end
    for (int l = 0; l < NL; l++) m_mem[l] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(line_state == '0, "R1", "all slots invalid", int'(line_state), 0);
    chk(rsp_valid == '0, "R1", "no response", int'(rsp_valid), 0);

    put(0, 0, 1, 0, 0); run();
    chk(st_of(0, 1) == 2, "R2", "lone read fills E", st_of(0, 1), 2);
    chk(got_rd[0] == 0, "R1", "memory reset value", got_rd[0], 0);

    b = bus_cnt;
    put(0, 1, 1, 'h11, 0); run();
    chk(st_of(0, 1) == 3, "R3", "E store to M", st_of(0, 1), 3);
    chk(bus_cnt == b, "R3", "silent store bus count", bus_cnt, b);

    put(1, 0, 1, 0, 0); run();
    chk(got_rd[1] == 'h11, "R6", "supplied data", got_rd[1], 'h11);
    chk(st_of(0, 1) == 1, "R6", "owner drops to S", st_of(0, 1), 1);
    chk(st_of(1, 1) == 1, "R2", "shared fill S", st_of(1, 1), 1);

    put(2, 0, 1, 0, 0); run();
    chk(got_rd[2] == 'h11, "R6", "memory written back", got_rd[2], 'h11);

    put(1, 1, 1, 'h22, 0); run();
    chk(last_cmd == 2, "R4", "upgrade command", last_cmd, 2);
    chk(st_of(1, 1) == 3 && st_of(0, 1) == 0 && st_of(2, 1) == 0, "R4",
        "upgrade invalidates peers", st_of(0, 1) + st_of(2, 1), 0);

    put(0, 1, 1, 'h33, 0); run();
    chk(last_cmd == 1, "R7", "rfo command", last_cmd, 1);
    chk(st_of(1, 1) == 0 && st_of(0, 1) == 3, "R7", "rfo moves ownership", st_of(1, 1), 0);

    put(0, 0, 1, 0, 0); run();
    chk(got_rd[0] == 'h33, "R11", "hit returns local data", got_rd[0], 'h33);

    put(2, 0, 1, 0, 0); run();
    put(1, 0, 1, 0, 0); run();
    put(1, 1, 1, 'h44, 1); run();
    chk(last_cmd == 3 && st_of(1, 1) == 1, "R5", "update keeps S", st_of(1, 1), 1);
    put(0, 0, 1, 0, 0); run();
    chk(got_rd[0] == 'h44 && st_of(0, 1) == 1, "R5", "peer copy updated", got_rd[0], 'h44);

    b = bus_cnt;
    put(0, 2, 1, 0, 0); run();
    chk(st_of(0, 1) == 0 && bus_cnt == b, "R8", "silent clean evict", bus_cnt, b);

    put(2, 1, 2, 'h55, 1); run();
    chk(st_of(2, 2) == 2, "R5", "unshared update fills E", st_of(2, 2), 2);
    put(2, 1, 2, 'h56, 0); run();
    b = bus_cnt;
    put(2, 2, 2, 0, 0); run();
    chk(bus_cnt == b + 1 && last_cmd == 4, "R8", "dirty evict writes back", last_cmd, 4);
    put(1, 0, 2, 0, 0); run();
    chk(got_rd[1] == 'h56 && st_of(1, 2) == 2, "R8", "memory holds evicted data", got_rd[1], 'h56);

    q_src.delete();
    put(0, 0, 0, 0, 0); put(1, 0, 0, 0, 0); put(2, 0, 0, 0, 0); run();
    chk(q_src.size() == 3, "R9", "one grant per cycle", q_src.size(), 3);
    if (q_src.size() == 3)
      chk(((1 << q_src[0]) | (1 << q_src[1]) | (1 << q_src[2])) == 7, "R9",
          "each core granted once", (1 << q_src[0]) | (1 << q_src[1]) | (1 << q_src[2]), 7);

    put(0, 1, 3, 'h66, 0); run();
    put(1, 1, 3, 'h77, 0); put(0, 0, 3, 0, 0); put(2, 0, 0, 0, 0); run();
    chk(acc_cyc[0] == acc_cyc[1] + 1, "R10", "same-block hit held off", acc_cyc[0], acc_cyc[1] + 1);
    chk(acc_cyc[2] == acc_cyc[1], "R10", "other block proceeds", acc_cyc[2], acc_cyc[1]);
    chk(got_rd[0] == 'h77, "R10", "held load sees new owner data", got_rd[0], 'h77);

    for (int n = 0; n < 4000 && !timed_out; n++) begin
      for (int c = 0; c < NC; c++)
        if (pv[c] == 0 && ($urandom % 3) != 0)
          put(c, int'($urandom % 3), int'($urandom % NL), int'($urandom % 256),
              int'($urandom % 2));
      step();
    end
    for (int c = 0; c < NC; c++) pv[c] = 0;
    step();

    if (timed_out) chk(1'b0, "R9", "watchdog expired", cyc, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule